// File: doc/BRIEF.md
# Early-Exit Integer Multiply/Divide Unit

This block runs one 32-bit integer multiply or divide at a time. An operation goes in through a valid/ready handshake together with a rename tag from the dispatch stage. The result comes back on a one-cycle output strobe carrying that same tag, so the caller can write it into the rename-buffer entry it reserved. While an operation is in flight the unit refuses new work. It becomes ready again in the cycle that carries the result, so a new operation can be accepted in that same cycle.

The multiplier walks the second operand eight bits per cycle, starting from the least significant chunk. It stops as soon as the bits not yet consumed are pure extension: all zeros for unsigned forms, or copies of the last consumed bit for signed forms. Small multipliers therefore finish in one or two cycles instead of four. The divider is an iterative restoring divider that runs on magnitudes, followed by one cycle that applies the quotient sign. Two illegal divides are caught at acceptance and return a fixed value with an exception flag one cycle later: any divisor of zero, and the signed quotient of the most negative value by minus one.

Top module: `imdu_top`

## Requirements
- R1: `in_ready` is high out of reset and whenever no operation is outstanding. After an operation is accepted (`in_valid` and `in_ready` high in the same cycle), `in_ready` stays low until the cycle in which `out_valid` presents its result, where it is high again. Each accepted operation produces exactly one single-cycle `out_valid` pulse.
- R2: `out_tag` in the result cycle equals the `in_tag` given with the accepted operation.
- R3: Opcodes 3'b000 (low word, unsigned) and 3'b011 (low word, signed) return bits 31:0 of the product of `in_a` and `in_b`.
- R4: Opcode 3'b001 returns bits 63:32 of the 64-bit two's-complement product of `in_a` and `in_b`, both taken as signed.
- R5: Opcode 3'b010 returns bits 63:32 of the 64-bit product of `in_a` and `in_b`, both taken as unsigned.
- R6: Timing, counted from the accepting cycle c. A multiply presents its result in cycle c+n+1. Here n (1 to 4) is the smallest number of 8-bit chunks of `in_b`, taken from the bottom, after which all higher bits of `in_b` are zero (opcodes 000 and 010) or equal to bit 8n-1 of `in_b` (opcodes 001 and 011). A regular divide presents its result in cycle c+34.
- R7: Opcode 3'b100 returns the unsigned quotient of `in_a` divided by `in_b`, rounded down, with `out_exc` low.
- R8: Opcode 3'b101 returns the signed quotient truncated toward zero, with `out_exc` low.
- R9: A divide with `in_b` equal to zero returns 32'hFFFF_FFFF with `out_exc` high, in cycle c+1. `out_exc` is low for every other result except the R10 case.
- R10: Opcode 3'b101 with `in_a` = 32'h8000_0000 and `in_b` = 32'hFFFF_FFFF returns 32'h8000_0000 with `out_exc` high, in cycle c+1.
- R11: For divides, bit 1 of `in_op` is ignored: 3'b110 behaves as 3'b100 and 3'b111 as 3'b101.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit can take an operation this cycle |
| in_op | input | 3 | Operation code (see R3 to R11) |
| in_a | input | 32 | First operand (multiplicand or dividend) |
| in_b | input | 32 | Second operand (multiplier or divisor) |
| in_tag | input | 4 | Rename tag assigned at dispatch |
| out_valid | output | 1 | One-cycle result strobe |
| out_result | output | 32 | Result word |
| out_tag | output | 4 | Tag of the returned result |
| out_exc | output | 1 | Illegal divide flag |

## Verification
A wrong chunk counter or a wrong early-exit test in the multiplier shows at the ports in two ways. The strobe arrives in the wrong cycle. If the unit stopped too soon, the high or low word is wrong, because the sign-correction term was applied at the wrong weight. The reference model predicts the exact cycle of every strobe and compares `in_ready` on every clock, so a single-cycle slip is reported in the cycle it happens. A bad divider step or a missed sign fix shows only in the quotient, which is compared 34 cycles after acceptance. A mis-decoded illegal divide shows one cycle after acceptance: either a missing strobe or a strobe with the wrong flag.

// File: rtl/imdu_pkg.sv
package imdu_pkg;

   // result source selected for the output mux
   typedef enum logic [1:0] {
      SEL_LO  = 2'd0,
      SEL_HI  = 2'd1,
      SEL_QUO = 2'd2,
      SEL_EXC = 2'd3
   } res_sel_e;

   // divider sequencing
   typedef enum logic [1:0] {
      DV_IDLE = 2'd0,
      DV_ITER = 2'd1,
      DV_FIX  = 2'd2
   } dv_state_e;

   // operation code fields
   localparam int OPB_DIV    = 2;   // 1: divide
   localparam int OPB_SIGNED = 0;   // 1: signed operands / signed early exit

   function automatic logic op_is_div(input logic [2:0] op);
      return op[OPB_DIV];
   endfunction

   function automatic logic op_signed(input logic [2:0] op);
      return op[OPB_SIGNED];
   endfunction

   // high word for 001 and 010, low word for 000 and 011
   function automatic logic op_high(input logic [2:0] op);
      return op[1] ^ op[0];
   endfunction

endpackage

// File: rtl/imdu_mul_core.sv
module imdu_mul_core #(
   parameter int XLEN       = 32,
   parameter int CHUNK      = 8,
   parameter bit EARLY_EXIT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              is_signed,
   input  logic [XLEN-1:0]   op_a,
   input  logic [XLEN-1:0]   op_b,
   output logic              done,
   output logic [2*XLEN-1:0] product
);
   localparam int PW     = 2 * XLEN;
   localparam int NCHUNK = XLEN / CHUNK;
   localparam int CW     = $clog2(NCHUNK + 1);

   logic              busy_q;
   logic              sgn_q;
   logic              done_q;
   logic [PW-1:0]     a_sh_q;
   logic [PW-1:0]     acc_q;
   logic [PW-1:0]     prod_q;
   logic [XLEN-1:0]   b_sh_q;
   logic [CW-1:0]     idx_q;

   logic [CHUNK-1:0]  chunk;
   logic [PW-1:0]     partial;
   logic [PW-1:0]     acc_sum;
   logic [PW-1:0]     a_next;
   logic [PW-1:0]     acc_final;
   logic [XLEN-1:0]   b_next;
   logic [XLEN-1:0]   fill;
   logic              neg_tail;
   logic              last_chunk;
   logic              finish;

   assign chunk      = b_sh_q[CHUNK-1:0];
   assign partial    = a_sh_q * {{(PW-CHUNK){1'b0}}, chunk};
   assign acc_sum    = acc_q + partial;
   assign a_next     = a_sh_q << CHUNK;
   assign neg_tail   = sgn_q & chunk[CHUNK-1];
   assign fill       = {XLEN{neg_tail}};
   assign last_chunk = (idx_q == CW'(NCHUNK - 1));
   // a negative tail weighs -2^(consumed bits); take one multiplicand at that weight back
   assign acc_final  = neg_tail ? (acc_sum - a_next) : acc_sum;

   always_comb begin
      if (sgn_q) b_next = $signed(b_sh_q) >>> CHUNK;
      else       b_next = b_sh_q >> CHUNK;
   end

   generate
      if (EARLY_EXIT) begin : g_early
         assign finish = last_chunk | (b_next == fill);
      end else begin : g_full
         assign finish = last_chunk;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         sgn_q  <= 1'b0;
         done_q <= 1'b0;
         a_sh_q <= '0;
         acc_q  <= '0;
         prod_q <= '0;
         b_sh_q <= '0;
         idx_q  <= '0;
      end else begin
         done_q <= 1'b0;
         if (start) begin
            busy_q <= 1'b1;
            sgn_q  <= is_signed;
            a_sh_q <= is_signed ? {{XLEN{op_a[XLEN-1]}}, op_a} : {{XLEN{1'b0}}, op_a};
            b_sh_q <= op_b;
            acc_q  <= '0;
            idx_q  <= '0;
         end else if (busy_q) begin
            acc_q  <= acc_sum;
            a_sh_q <= a_next;
            b_sh_q <= b_next;
            idx_q  <= idx_q + 1'b1;
            if (finish) begin
               busy_q <= 1'b0;
               prod_q <= acc_final;
               done_q <= 1'b1;
            end
         end
      end
   end

   assign done    = done_q;
   assign product = prod_q;

   p_chunk_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (idx_q < CW'(NCHUNK)));

   p_mul_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

   p_no_start_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> !start);

endmodule

// File: rtl/imdu_div_core.sv
module imdu_div_core #(
   parameter int XLEN = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic            neg_res,
   input  logic [XLEN-1:0] dividend,
   input  logic [XLEN-1:0] divisor,
   output logic            done,
   output logic [XLEN-1:0] quotient
);
   import imdu_pkg::*;

   localparam int CW = $clog2(XLEN + 1);

   dv_state_e       state_q;
   logic [XLEN-1:0] rem_q;
   logic [XLEN-1:0] quo_q;
   logic [XLEN-1:0] dvs_q;
   logic [XLEN-1:0] res_q;
   logic [CW-1:0]   cnt_q;
   logic            neg_q;
   logic            done_q;

   logic [XLEN:0]   r_sh;
   logic [XLEN:0]   diff;
   logic            take;

   assign r_sh = {rem_q, quo_q[XLEN-1]};
   assign diff = r_sh - {1'b0, dvs_q};
   assign take = ~diff[XLEN];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= DV_IDLE;
         rem_q   <= '0;
         quo_q   <= '0;
         dvs_q   <= '0;
         res_q   <= '0;
         cnt_q   <= '0;
         neg_q   <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            DV_IDLE: begin
               if (start) begin
                  rem_q   <= '0;
                  quo_q   <= dividend;
                  dvs_q   <= divisor;
                  neg_q   <= neg_res;
                  cnt_q   <= '0;
                  state_q <= DV_ITER;
               end
            end
            DV_ITER: begin
               rem_q <= take ? diff[XLEN-1:0] : r_sh[XLEN-1:0];
               quo_q <= {quo_q[XLEN-2:0], take};
               cnt_q <= cnt_q + 1'b1;
               if (cnt_q == CW'(XLEN - 1)) state_q <= DV_FIX;
            end
            DV_FIX: begin
               res_q   <= neg_q ? (~quo_q + 1'b1) : quo_q;
               done_q  <= 1'b1;
               state_q <= DV_IDLE;
            end
            default: state_q <= DV_IDLE;
         endcase
      end
   end

   assign done     = done_q;
   assign quotient = res_q;

   p_rem_below_div_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == DV_FIX) |-> (rem_q < dvs_q));

   p_iter_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == DV_ITER) |-> (cnt_q < CW'(XLEN)));

   p_nonzero_div_r9: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> (divisor != '0));

   p_div_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

endmodule

// File: rtl/imdu_top.sv
module imdu_top #(
   parameter int XLEN       = 32,
   parameter int CHUNK      = 8,
   parameter int TAG_W      = 4,
   parameter bit EARLY_EXIT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [2:0]       in_op,
   input  logic [XLEN-1:0]  in_a,
   input  logic [XLEN-1:0]  in_b,
   input  logic [TAG_W-1:0] in_tag,
   output logic             out_valid,
   output logic [XLEN-1:0]  out_result,
   output logic [TAG_W-1:0] out_tag,
   output logic             out_exc
);
   import imdu_pkg::*;

   localparam logic [XLEN-1:0] MIN_NEG = {1'b1, {(XLEN-1){1'b0}}};
   localparam logic [XLEN-1:0] ALL_ONE = {XLEN{1'b1}};

   if (CHUNK < 1 || (XLEN % CHUNK) != 0) begin : g_bad_chunk
      $error("imdu_top: CHUNK must divide XLEN");
   end
   if (XLEN < 2 || TAG_W < 1) begin : g_bad_width
      $error("imdu_top: XLEN must be at least 2 and TAG_W at least 1");
   end

   logic             accept;
   logic             is_div;
   logic             sgn;
   logic             dz;
   logic             ovf;
   logic             exc_now;
   logic             mul_start;
   logic             div_start;
   logic             div_neg;
   logic [XLEN-1:0]  a_mag;
   logic [XLEN-1:0]  b_mag;
   logic             mul_done;
   logic             div_done;
   logic [2*XLEN-1:0] mul_prod;
   logic [XLEN-1:0]  div_quo;

   logic             busy_q;
   logic             exc_q;
   logic [XLEN-1:0]  exc_res_q;
   logic [TAG_W-1:0] tag_q;
   res_sel_e         sel_q;

   assign accept    = in_valid & in_ready;
   assign is_div    = op_is_div(in_op);
   assign sgn       = op_signed(in_op);
   assign dz        = (in_b == '0);
   assign ovf       = sgn & (in_a == MIN_NEG) & (in_b == ALL_ONE);
   assign exc_now   = is_div & (dz | ovf);
   assign mul_start = accept & ~is_div;
   assign div_start = accept & is_div & ~exc_now;
   assign a_mag     = (sgn & in_a[XLEN-1]) ? (~in_a + 1'b1) : in_a;
   assign b_mag     = (sgn & in_b[XLEN-1]) ? (~in_b + 1'b1) : in_b;
   assign div_neg   = sgn & (in_a[XLEN-1] ^ in_b[XLEN-1]);

   imdu_mul_core #(
      .XLEN      (XLEN),
      .CHUNK     (CHUNK),
      .EARLY_EXIT(EARLY_EXIT)
   ) mul_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (mul_start),
      .is_signed(sgn),
      .op_a     (in_a),
      .op_b     (in_b),
      .done     (mul_done),
      .product  (mul_prod)
   );

   imdu_div_core #(
      .XLEN(XLEN)
   ) div_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (div_start),
      .neg_res (div_neg),
      .dividend(a_mag),
      .divisor (b_mag),
      .done    (div_done),
      .quotient(div_quo)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q    <= 1'b0;
         exc_q     <= 1'b0;
         exc_res_q <= '0;
         tag_q     <= '0;
         sel_q     <= SEL_LO;
      end else begin
         exc_q <= accept & exc_now;
         if (accept) begin
            busy_q <= 1'b1;
            tag_q  <= in_tag;
            if (is_div) begin
               sel_q     <= exc_now ? SEL_EXC : SEL_QUO;
               exc_res_q <= dz ? ALL_ONE : MIN_NEG;
            end else begin
               sel_q <= op_high(in_op) ? SEL_HI : SEL_LO;
            end
         end else if (out_valid) begin
            busy_q <= 1'b0;
         end
      end
   end

   assign out_valid = mul_done | div_done | exc_q;
   assign in_ready  = ~busy_q | out_valid;
   assign out_tag   = tag_q;
   assign out_exc   = exc_q;

   always_comb begin
      case (sel_q)
         SEL_LO:  out_result = mul_prod[XLEN-1:0];
         SEL_HI:  out_result = mul_prod[2*XLEN-1:XLEN];
         SEL_QUO: out_result = div_quo;
         default: out_result = exc_res_q;
      endcase
   end

   p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q |-> !(mul_done || div_done || exc_q));

   p_single_source_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mul_done, div_done, exc_q}));

   p_exc_route_r9: assert property (@(posedge clk) disable iff (!rst_n)
      exc_q |-> (sel_q == SEL_EXC));

   p_tag_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !out_valid) |=> $stable(out_tag));

endmodule

// File: tb/imdu_top_tb_top.sv
module imdu_top_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [2:0]  in_op = '0;
   logic [31:0] in_a = '0;
   logic [31:0] in_b = '0;
   logic [3:0]  in_tag = '0;
   logic        out_valid;
   logic [31:0] out_result;
   logic [3:0]  out_tag;
   logic        out_exc;

   always #4 clk = ~clk;   // 125 MHz

   imdu_top #(.XLEN(32), .CHUNK(8), .TAG_W(4), .EARLY_EXIT(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_op(in_op), .in_a(in_a), .in_b(in_b), .in_tag(in_tag),
      .out_valid(out_valid), .out_result(out_result), .out_tag(out_tag),
      .out_exc(out_exc)
   );

   typedef struct {
      int          due;
      logic [31:0] res;
      logic [3:0]  tag;
      logic        exc;
      string       req;
   } exp_t;

   exp_t q[$];
   int   checks = 0;
   int   errors = 0;
   int   cyc = 0;
   bit   finished = 0;
   logic [3:0] next_tag = 4'd0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
      end
   endtask

   function automatic bit fits(input logic [31:0] b, input bit sgn, input int k);
      int sv;
      sv = int'(b);
      if (sgn) return ((sv >>> (8*k-1)) == 0) || ((sv >>> (8*k-1)) == -1);
      if (k >= 4) return 1'b1;
      return (b >> (8*k)) == 32'd0;
   endfunction

   task automatic ref_op(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                         output logic [31:0] res, output logic exc, output int lat,
                         output string req);
      longint          sp;
      longint unsigned up;
      int              n;
      exc = 1'b0;
      if (op[2]) begin
         if (b == 32'd0) begin
            res = 32'hFFFF_FFFF; exc = 1'b1; lat = 1; req = "R9";
         end else if (op[0] && a == 32'h8000_0000 && b == 32'hFFFF_FFFF) begin
            res = 32'h8000_0000; exc = 1'b1; lat = 1; req = "R10";
         end else begin
            lat = 34;
            if (op[0]) begin res = 32'(int'(a) / int'(b)); req = "R8"; end
            else       begin res = a / b;                  req = "R7"; end
            if (op[1]) req = "R11";
         end
      end else begin
         sp = longint'(int'(a)) * longint'(int'(b));
         up = {32'd0, a} * {32'd0, b};
         case (op[1:0])
            2'b01:   begin res = sp[63:32]; req = "R4"; end
            2'b10:   begin res = up[63:32]; req = "R5"; end
            default: begin res = up[31:0];  req = "R3"; end
         endcase
         n = 4;
         for (int k = 4; k >= 1; k--) if (fits(b, op[0], k)) n = k;
         lat = n + 1;
      end
   endtask

   task automatic step(input logic v, input logic [2:0] op, input logic [31:0] a,
                       input logic [31:0] b, output logic acc);
      logic  vexp, rexp, e_exc;
      exp_t  e;
      int    lat;
      logic [31:0] e_res;
      string e_req;
      @(negedge clk);
      cyc++;
      vexp = (q.size() > 0) && (q[0].due == cyc);
      rexp = (q.size() == 0) || vexp;
      chk(in_ready == rexp, "R1", "in_ready", 64'(in_ready), 64'(rexp));
      chk(out_valid == vexp, "R6", "out_valid timing", 64'(out_valid), 64'(vexp));
      if (vexp) begin
         e = q.pop_front();
         if (out_valid) begin
            chk(out_result == e.res, e.req, "out_result", 64'(out_result), 64'(e.res));
            chk(out_tag == e.tag, "R2", "out_tag", 64'(out_tag), 64'(e.tag));
            chk(out_exc == e.exc, e.exc ? e.req : "R9", "out_exc", 64'(out_exc), 64'(e.exc));
         end
      end
      in_valid = v;
      in_op    = op;
      in_a     = a;
      in_b     = b;
      in_tag   = next_tag;
      acc      = v && rexp;
      if (acc) begin
         ref_op(op, a, b, e_res, e_exc, lat, e_req);
         e.due = cyc + lat; e.res = e_res; e.tag = next_tag; e.exc = e_exc; e.req = e_req;
         q.push_back(e);
         next_tag = next_tag + 4'd3;
      end
   endtask

   task automatic issue(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
      logic acc;
      acc = 1'b0;
      while (!acc) step(1'b1, op, a, b, acc);
   endtask

   task automatic idle(input int n);
      logic acc;
      for (int i = 0; i < n; i++) step(1'b0, 3'd0, 32'd0, 32'd0, acc);
   endtask

   task automatic drain();
      while (q.size() > 0) idle(1);
      idle(1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(in_ready == 1'b1, "R1", "reset in_ready", 64'(in_ready), 64'd1);
      chk(out_valid == 1'b0, "R1", "reset out_valid", 64'(out_valid), 64'd0);
      rst_n = 1'b1;
      idle(2);

      // multiply early-exit lengths (R6) and word selects (R3 R4 R5)
      issue(3'b000, 32'h1234_5678, 32'h0000_0000); drain();
      issue(3'b000, 32'hDEAD_BEEF, 32'h0000_0100); drain();
      issue(3'b010, 32'hFFFF_FFFF, 32'h0001_2345); drain();
      issue(3'b010, 32'hFFFF_FFFF, 32'h8000_0000); drain();
      issue(3'b001, 32'h8000_0000, 32'hFFFF_FFFF); drain();
      issue(3'b001, 32'h7FFF_FFFF, 32'hFFFF_FF38); drain();
      issue(3'b011, 32'hF000_000F, 32'h0000_0080); drain();
      issue(3'b001, 32'h8000_0000, 32'h8000_0000); drain();
      issue(3'b001, 32'h1234_5678, 32'h0000_007F); drain();
      // back-to-back: accept in result cycle
      issue(3'b000, 32'd7, 32'd9);
      issue(3'b010, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
      issue(3'b011, 32'hFFFF_FFF0, 32'hFFFF_FFFE); drain();

      // divides (R7 R8 R11) and illegal cases (R9 R10)
      issue(3'b100, 32'd100, 32'd7); drain();
      issue(3'b101, 32'hFFFF_FF9C, 32'd7); drain();
      issue(3'b101, 32'd100, 32'hFFFF_FFF9); drain();
      issue(3'b100, 32'hFFFF_FFFF, 32'd1); drain();
      issue(3'b101, 32'h8000_0000, 32'd1); drain();
      issue(3'b110, 32'hF000_0000, 32'd3); drain();
      issue(3'b111, 32'hF000_0000, 32'd3); drain();
      issue(3'b101, 32'h8000_0000, 32'hFFFF_FFFF);
      issue(3'b100, 32'd55, 32'd0);
      issue(3'b101, 32'h8000_0000, 32'd0);
      issue(3'b111, 32'h8000_0000, 32'hFFFF_FFFF); drain();
      issue(3'b100, 32'd3, 32'd10); drain();

      // mixed traffic with gaps and offers while busy
      for (int i = 0; i < 300; i++) begin
         logic [2:0]  op;
         logic [31:0] a, b;
         int          sh;
         op = 3'($urandom_range(0, 7));
         a  = $urandom;
         b  = $urandom;
         sh = $urandom_range(0, 4);
         if (sh == 4) b = 32'd0;
         else if ($urandom_range(0, 1) == 1) b = 32'(int'(b) >>> (8*sh));
         else b = b >> (8*sh);
         if ($urandom_range(0, 15) == 0) a = 32'h8000_0000;
         issue(op, a, b);
         if ($urandom_range(0, 2) == 0) idle($urandom_range(1, 3));
      end
      drain();

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule